// File: doc/BRIEF.md
# CAN Receive Bit Destuffer

This block sits in a CAN receive path between the bit sampler and the frame parser. Each sampled bus bit arrives with a one-cycle valid strobe. The block forwards only the bits that belong to the frame and drops the stuff bits the transmitter inserted. Each dropped bit is reported on a separate strobe, so the parser's bit numbering is not disturbed.

The block tracks the run of equal raw bits it has seen. Stuff bits count in that run, so a stuff bit can start a new run. Once a run reaches five bits, the next raw bit must be the complement. That bit is a stuff bit and is removed. If the bit equals the run instead, the block reports a stuff error.

The parser drives an enable low for the fixed-form tail of the frame: CRC delimiter, ACK slot, ACK delimiter and end-of-frame. While the enable is low, every bit passes through unchanged. A start-of-frame flag on the first raw bit clears the run history. Every output appears one clock after the input strobe that caused it.

Top module: `can_destuff`

## Requirements
- R1: After reset, `bit_valid_o`, `stuff_o` and `stuff_error_o` are all low.
- R2: A raw bit that is not classed as a stuff bit or a stuff error shows up on `bit_o` with `bit_valid_o` high, exactly one clock after its `bit_valid_i` strobe.
- R3: While `destuff_en_i` is high, a raw bit that follows five equal raw bits and differs from them is removed. One clock later `stuff_o` pulses and `bit_valid_o` stays low.
- R4: A removed stuff bit is part of the raw history and starts a new run of length 1. Four more raw bits equal to the stuff bit therefore make the following complementary bit a stuff bit too.
- R5: While `destuff_en_i` is high, a raw bit that equals the five equal raw bits before it causes a one-cycle `stuff_error_o` pulse one clock later. That bit is not forwarded, and it restarts the history as a run of length 1.
- R6: While `destuff_en_i` is low, every raw bit is forwarded and neither `stuff_o` nor `stuff_error_o` pulses. Those bits are still added to the run history.
- R7: A raw bit strobed with `sof_i` high is always forwarded as a frame bit. It discards all earlier history and starts a run of length 1.
- R8: A clock with `bit_valid_i` low produces no output strobe in the following cycle.
- R9: At most one of `bit_valid_o`, `stuff_o` and `stuff_error_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Raw sampled bus bit (0 = dominant) |
| bit_valid_i | input | 1 | One-cycle strobe qualifying `bit_i` |
| sof_i | input | 1 | Marks the strobed bit as start of frame |
| destuff_en_i | input | 1 | High enables stuff-bit removal and checking |
| bit_o | output | 1 | Forwarded bit value |
| bit_valid_o | output | 1 | Strobe for a forwarded frame bit |
| stuff_o | output | 1 | Strobe for a removed stuff bit |
| stuff_error_o | output | 1 | Pulse for six equal raw bits while enabled |

## Verification
The bench sweeps every 10-bit pattern that follows a start-of-frame bit. It compares each output against a model that keeps a window of the most recent raw bits instead of a run counter.

The corner cases it targets are:
- A stuff bit that must itself seed the next run. A design that leaves stuff bits out of the history misses the second stuff bit.
- A run longer than five while destuffing is disabled. A design that stops tracking there gets the first enabled bit wrong.
- A start-of-frame bit in the middle of a run. Stale history would make the block strip a real frame bit.
- Six equal bits. A design that still forwards the bit, or does not restart the run, shifts the parser's bit count or raises an error again on the next bit.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_STUFF = 2'd2,
    CLS_ERR   = 2'd3
  } bit_class_e;
endpackage

// File: rtl/can_run_tracker.sv
module can_run_tracker #(
  parameter int STUFF_RUN = 5,
  localparam int CNT_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic             bit_i,
  output logic             run_val_o,
  output logic [CNT_W-1:0] run_len_o
);
  logic             run_val_q;
  logic [CNT_W-1:0] run_len_q;

  // run length saturates at STUFF_RUN; 0 means no history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_val_q <= 1'b1;
      run_len_q <= '0;
    end else if (adv_i) begin
      if (restart_i || run_len_q == '0 || bit_i != run_val_q) begin
        run_val_q <= bit_i;
        run_len_q <= CNT_W'(1);
      end else if (run_len_q != CNT_W'(STUFF_RUN)) begin
        run_len_q <= run_len_q + CNT_W'(1);
      end
    end
  end

  assign run_val_o = run_val_q;
  assign run_len_o = run_len_q;

  assert_run_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= CNT_W'(STUFF_RUN));
  assert_restart_len_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && restart_i) |=> (run_len_q == CNT_W'(1)));
endmodule

// File: rtl/can_stuff_classifier.sv
module can_stuff_classifier
  import can_destuff_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  localparam int CNT_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic             run_val_i,
  input  logic [CNT_W-1:0] run_len_i,
  output bit_class_e       cls_o
);
  logic run_full;
  assign run_full = (run_len_i == CNT_W'(STUFF_RUN));

  always_comb begin
    if (!valid_i)                       cls_o = CLS_NONE;
    else if (sof_i || !en_i || !run_full) cls_o = CLS_DATA;
    else if (bit_i != run_val_i)        cls_o = CLS_STUFF;
    else                                cls_o = CLS_ERR;
  end
endmodule

// File: rtl/can_destuff_out.sv
module can_destuff_out
  import can_destuff_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bit_class_e cls_i,
  input  logic       bit_i,
  output logic       bit_o,
  output logic       bit_valid_o,
  output logic       stuff_o,
  output logic       stuff_error_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o         <= 1'b1;
      bit_valid_o   <= 1'b0;
      stuff_o       <= 1'b0;
      stuff_error_o <= 1'b0;
    end else begin
      if (cls_i != CLS_NONE) bit_o <= bit_i;
      bit_valid_o   <= (cls_i == CLS_DATA);
      stuff_o       <= (cls_i == CLS_STUFF);
      stuff_error_o <= (cls_i == CLS_ERR);
    end
  end
endmodule

// File: rtl/can_destuff.sv
module can_destuff
  import can_destuff_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  input  logic sof_i,
  input  logic destuff_en_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic stuff_o,
  output logic stuff_error_o
);
  localparam int CNT_W = $clog2(STUFF_RUN + 1);

  logic             run_val;
  logic [CNT_W-1:0] run_len;
  bit_class_e       cls;
  logic             restart;

  // an error bit also restarts the run (R5)
  assign restart = sof_i || (cls == CLS_ERR);

  can_run_tracker #(.STUFF_RUN(STUFF_RUN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (bit_valid_i),
    .restart_i (restart),
    .bit_i     (bit_i),
    .run_val_o (run_val),
    .run_len_o (run_len)
  );

  can_stuff_classifier #(.STUFF_RUN(STUFF_RUN)) u_cls (
    .valid_i   (bit_valid_i),
    .sof_i     (sof_i),
    .en_i      (destuff_en_i),
    .bit_i     (bit_i),
    .run_val_i (run_val),
    .run_len_i (run_len),
    .cls_o     (cls)
  );

  can_destuff_out u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cls_i         (cls),
    .bit_i         (bit_i),
    .bit_o         (bit_o),
    .bit_valid_o   (bit_valid_o),
    .stuff_o       (stuff_o),
    .stuff_error_o (stuff_error_o)
  );

  assert_single_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_valid_o, stuff_o, stuff_error_o}));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !(bit_valid_o || stuff_o || stuff_error_o));
  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && !destuff_en_i) |=> (bit_valid_o && bit_o == $past(bit_i)));
  assert_sof_forward_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && sof_i) |=> bit_valid_o);
  assert_stuff_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && cls == CLS_STUFF) |-> destuff_en_i);
  assert_error_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_error_o |=> !stuff_error_o);
endmodule

// File: tb/can_destuff_tb_top.sv
module can_destuff_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b1, valid_in = 1'b0, sof_in = 1'b0, en_in = 1'b1;
  logic bit_out, valid_out, stuff_out, err_out;

  int checks = 0;
  int errors = 0;

  // model: last five raw bits, h[0] newest, h_n bits of history
  logic [4:0] h = '0;
  int         h_n = 0;

  always #10 clk = ~clk;

  can_destuff dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_valid_i(valid_in),
    .sof_i(sof_in), .destuff_en_i(en_in), .bit_o(bit_out),
    .bit_valid_o(valid_out), .stuff_o(stuff_out), .stuff_error_o(err_out)
  );

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,stuff,err,bit} act=%b exp=%b", tag, act, exp);
    end
  endtask

  // kind: 0 data, 1 stuff, 2 error
  task automatic send(input logic b, input logic s, input logic en);
    int kind;
    string tag;
    if (s) begin
      kind = 0; h = {4'b0, b}; h_n = 1;
    end else if (en && h_n >= 5 && (h == 5'b11111 || h == 5'b00000)) begin
      if (b != h[0]) begin
        kind = 1; h = {h[3:0], b}; h_n++;
      end else begin
        kind = 2; h = {4'b0, b}; h_n = 1;
      end
    end else begin
      kind = 0; h = {h[3:0], b}; h_n++;
    end
    tag = s ? "R7" : !en ? "R6" : kind == 1 ? "R3" : kind == 2 ? "R5" : "R2";
    bit_in = b; sof_in = s; en_in = en; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0; sof_in = 1'b0;
    chk(tag, {valid_out, stuff_out, err_out, (kind == 0) ? bit_out : 1'b0},
        {kind == 0, kind == 1, kind == 2, (kind == 0) ? b : 1'b0});
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R8", {valid_out, stuff_out, err_out, 1'b0}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {valid_out, stuff_out, err_out, 1'b0}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {valid_out, stuff_out, err_out, 1'b0}, 4'b0000);

    // R4: stuff bit seeds a new run
    send(0, 1, 1);
    for (int i = 0; i < 5; i++) send(1, 0, 1);
    send(0, 0, 1);
    for (int i = 0; i < 4; i++) send(0, 0, 1);
    send(1, 0, 1);
    chk("R4", {valid_out, stuff_out, err_out, 1'b0}, 4'b0100);
    idle_check();

    // R7: SOF mid-run clears history
    for (int i = 0; i < 4; i++) send(1, 0, 0);
    send(1, 1, 1);
    for (int i = 0; i < 4; i++) send(1, 0, 1);
    send(0, 0, 1);
    chk("R7", {valid_out, stuff_out, err_out, 1'b0}, 4'b0100);
    idle_check();

    // R5 then R6: error restart, then a long run while disabled
    send(0, 1, 1);
    for (int i = 0; i < 5; i++) send(0, 0, 1);
    chk("R5", {valid_out, stuff_out, err_out, 1'b0}, 4'b0010);
    for (int i = 0; i < 8; i++) send(1, 0, 0);
    send(1, 0, 1);
    chk("R6", {valid_out, stuff_out, err_out, 1'b0}, 4'b0010);
    idle_check();

    // exhaustive: all 10-bit tails after SOF, destuffing enabled
    for (int p = 0; p < 1024; p++) begin
      send(0, 1, 1);
      for (int k = 9; k >= 0; k--) send(p[k], 0, 1);
      idle_check();
    end

    // exhaustive tails with a varying enable pattern
    for (int p = 0; p < 1024; p++) begin
      int m;
      m = (p * 7 + 3) ^ 10'h2c5;
      send(p[0], 1, 1);
      for (int k = 9; k >= 0; k--) send(p[k], 0, m[k]);
      idle_check();
    end

    finish_run();
  end
endmodule